// File: doc/BRIEF.md
# Power-On Configuration Loader Sequencer

This block controls how a device starts up. When the power-good input goes high, an internal power-on reset timer runs for a fixed number of clock cycles. When the timer expires, the block reads one complete configuration image from a non-volatile store. The image is one of up to four, chosen by a select input. Each word is copied into the working register file at the same index. Only after the last word is written does the block raise a one-cycle request to start PLL lock, and then open the serial register port.

Serial reads and writes made before the block is ready do not touch the registers. Each one is answered with a not-ready pulse. Once the block is ready, serial writes change the working registers. Those changes last only until power-good falls again. Any drop of power-good returns the block to the timer state, clears the registers, and forces the stored image to be reloaded.

Top module: `cfg_boot_seq`

## Requirements
- R1: After power-good rises, `store_rd_en` stays low and `busy` stays high for POR_CYCLES rising clock edges. The first store read is presented right after edge number POR_CYCLES.
- R2: The loader presents store reads on N_WORDS consecutive cycles. The address is `{image, index}`, with the image in the upper IMG_W bits and the index counting 0 to N_WORDS-1 in the lower IDX_W bits.
- R3: Store data returns one cycle after each read. Each word is written to the working register with the same index, so that after loading, serial reads return the selected image word for word.
- R4: `pll_lock_start` is high for exactly one cycle. That cycle comes two cycles after the last store read is presented, while `busy` is still high.
- R5: `ready` rises on the cycle after `pll_lock_start` and stays high until power-good falls. `busy` is always the inverse of `ready`.
- R6: A serial read or write made while `busy` is high leaves the registers and `ser_rdata` unchanged. It raises `ser_nack` for one cycle, on the cycle after the attempt.
- R7: While `ready` is high, a serial write updates the addressed register. A serial read returns the register's value in `ser_rdata` one cycle later. `ser_nack` stays low.
- R8: Power-good low forces the reset state from any state: `busy`=1, `ready`=0, `pll_lock_start`=0, `store_rd_en`=0, `ser_nack`=0, `ser_rdata`=0. Registers written over the serial port are then replaced by the stored image on the next load.
- R9: `img_sel` is sampled only on the cycle the power-on timer expires. Changes to it during loading have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Raw power-good; low acts as asynchronous reset |
| img_sel | input | IMG_W | Selects the stored image to load |
| store_rd_en | output | 1 | Store read strobe |
| store_addr | output | IMG_W+IDX_W | Store address {image, index} |
| store_rdata | input | DATA_W | Store data, valid one cycle after the read strobe |
| ser_wr_en | input | 1 | Serial write strobe |
| ser_rd_en | input | 1 | Serial read strobe |
| ser_addr | input | IDX_W | Serial register index |
| ser_wdata | input | DATA_W | Serial write data |
| ser_rdata | output | DATA_W | Serial read data, registered |
| ser_nack | output | 1 | Pulse: serial access made while busy |
| busy | output | 1 | Start-up sequence in progress |
| ready | output | 1 | Configuration loaded, serial port open |
| pll_lock_start | output | 1 | One-cycle request to start PLL lock |

## Verification
The bench builds the block with POR_CYCLES=12, N_WORDS=8, four images and 8-bit data. The timer window and the whole image then fit into a few dozen cycles, so every cycle of the timer and the load is checked. All four images are booted in turn, and the expected contents are computed from the store address. Serial writes made between boots show that the next power cycle discards them. One boot is also cut off in the middle of loading.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

    typedef enum logic [1:0] {
        ST_POR_WAIT = 2'd0,
        ST_LOAD     = 2'd1,
        ST_LOCK_REQ = 2'd2,
        ST_READY    = 2'd3
    } boot_state_e;

endpackage

// File: rtl/cfg_boot_por_timer.sv
module cfg_boot_por_timer #(
    parameter int unsigned POR_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = run && (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (!expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cfg_boot_load_seq.sv
module cfg_boot_load_seq #(
    parameter int unsigned N_WORDS = 16,
    localparam int unsigned IDX_W = $clog2(N_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             done
);
    localparam int unsigned CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] TOTAL    = CNT_W'(N_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] issued;
        logic             wr_valid;
        logic [IDX_W-1:0] wr_idx;
    } seq_t;

    seq_t d, q;

    always_comb begin
        rd_en  = active && (q.issued < TOTAL);
        rd_idx = q.issued[IDX_W-1:0];
        d      = q;
        if (!active) begin
            d.issued = '0;
        end else if (rd_en) begin
            d.issued = q.issued + 1'b1;
        end
        d.wr_valid = rd_en;
        d.wr_idx   = rd_idx;
        wr_en  = q.wr_valid;
        wr_idx = q.wr_idx;
        done   = q.wr_valid && (q.wr_idx == LAST_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cfg_boot_regfile.sv
module cfg_boot_regfile #(
    parameter int unsigned N_WORDS = 16,
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned IDX_W  = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_d [N_WORDS];
    logic [DATA_W-1:0] mem_q [N_WORDS];

    always_comb begin
        for (int i = 0; i < int'(N_WORDS); i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we && (int'(waddr) < int'(N_WORDS))) begin
            mem_d[waddr] = wdata;
        end
        rdata = (int'(raddr) < int'(N_WORDS)) ? mem_q[raddr] : '0;
    end

    generate
        for (genvar g = 0; g < int'(N_WORDS); g++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else begin
                    mem_q[g] <= mem_d[g];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
    import cfg_boot_pkg::*;
#(
    parameter int unsigned POR_CYCLES = 1000000,
    parameter int unsigned NUM_IMAGES = 4,
    parameter int unsigned N_WORDS    = 16,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned IMG_W  = (NUM_IMAGES > 1) ? $clog2(NUM_IMAGES) : 1,
    localparam int unsigned IDX_W  = $clog2(N_WORDS),
    localparam int unsigned ADDR_W = IMG_W + IDX_W
) (
    input  logic              clk,
    input  logic              pwr_good,
    input  logic [IMG_W-1:0]  img_sel,
    output logic              store_rd_en,
    output logic [ADDR_W-1:0] store_addr,
    input  logic [DATA_W-1:0] store_rdata,
    input  logic              ser_wr_en,
    input  logic              ser_rd_en,
    input  logic [IDX_W-1:0]  ser_addr,
    input  logic [DATA_W-1:0] ser_wdata,
    output logic [DATA_W-1:0] ser_rdata,
    output logic              ser_nack,
    output logic              busy,
    output logic              ready,
    output logic              pll_lock_start
);
    typedef struct packed {
        boot_state_e       state;
        logic [IMG_W-1:0]  img;
        logic [DATA_W-1:0] rdata;
        logic              nack;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{state: ST_POR_WAIT, img: '0, rdata: '0, nack: 1'b0};

    ctl_t d, q;

    logic              por_expired;
    logic              ld_rd_en;
    logic [IDX_W-1:0]  ld_rd_idx;
    logic              ld_wr_en;
    logic [IDX_W-1:0]  ld_wr_idx;
    logic              ld_done;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] rf_rdata;
    logic              is_ready;

    cfg_boot_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk     (clk),
        .rst_n   (pwr_good),
        .run     (q.state == ST_POR_WAIT),
        .expired (por_expired)
    );

    cfg_boot_load_seq #(.N_WORDS(N_WORDS)) u_load (
        .clk    (clk),
        .rst_n  (pwr_good),
        .active (q.state == ST_LOAD),
        .rd_en  (ld_rd_en),
        .rd_idx (ld_rd_idx),
        .wr_en  (ld_wr_en),
        .wr_idx (ld_wr_idx),
        .done   (ld_done)
    );

    cfg_boot_regfile #(.N_WORDS(N_WORDS), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (pwr_good),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (ser_addr),
        .rdata (rf_rdata)
    );

    always_comb begin
        d        = q;
        is_ready = (q.state == ST_READY);

        unique case (q.state)
            ST_POR_WAIT: begin
                if (por_expired) begin
                    d.state = ST_LOAD;
                    d.img   = img_sel;
                end
            end
            ST_LOAD: begin
                if (ld_done) begin
                    d.state = ST_LOCK_REQ;
                end
            end
            ST_LOCK_REQ: d.state = ST_READY;
            ST_READY:    d.state = ST_READY;
            default:     d.state = ST_POR_WAIT;
        endcase

        d.nack = (ser_wr_en || ser_rd_en) && !is_ready;
        if (is_ready && ser_rd_en) begin
            d.rdata = rf_rdata;
        end

        rf_we    = ld_wr_en || (is_ready && ser_wr_en);
        rf_waddr = ld_wr_en ? ld_wr_idx : ser_addr;
        rf_wdata = ld_wr_en ? store_rdata : ser_wdata;

        store_rd_en    = ld_rd_en;
        store_addr     = {q.img, ld_rd_idx};
        ser_rdata      = q.rdata;
        ser_nack       = q.nack;
        busy           = !is_ready;
        ready          = is_ready;
        pll_lock_start = (q.state == ST_LOCK_REQ);
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            q <= CTL_RESET;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cfg_boot_seq_chk.sv
module cfg_boot_seq_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              pwr_good,
    input logic              busy,
    input logic              ready,
    input logic              pll_lock_start,
    input logic              store_rd_en,
    input logic [ADDR_W-1:0] store_addr,
    input logic              ser_wr_en,
    input logic              ser_rd_en,
    input logic              ser_nack
);
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!pwr_good)
        (store_rd_en && $past(store_rd_en)) |-> (store_addr == $past(store_addr) + 1'b1));

    assert_read_only_busy_R2: assert property (@(posedge clk) disable iff (!pwr_good)
        store_rd_en |-> (busy && !pll_lock_start));

    assert_lock_while_busy_R4: assert property (@(posedge clk) disable iff (!pwr_good)
        pll_lock_start |-> (busy && !store_rd_en));

    assert_lock_then_ready_R4: assert property (@(posedge clk) disable iff (!pwr_good)
        pll_lock_start |=> (ready && !pll_lock_start));

    assert_busy_ready_excl_R5: assert property (@(posedge clk) disable iff (!pwr_good)
        busy != ready);

    assert_ready_sticks_R5: assert property (@(posedge clk) disable iff (!pwr_good)
        ready |=> ready);

    assert_nack_on_busy_R6: assert property (@(posedge clk) disable iff (!pwr_good)
        ((ser_wr_en || ser_rd_en) && busy) |=> ser_nack);

    assert_no_nack_ready_R7: assert property (@(posedge clk) disable iff (!pwr_good)
        (ready && $past(ready)) |-> !ser_nack);
endmodule

bind cfg_boot_seq cfg_boot_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .pwr_good       (pwr_good),
    .busy           (busy),
    .ready          (ready),
    .pll_lock_start (pll_lock_start),
    .store_rd_en    (store_rd_en),
    .store_addr     (store_addr),
    .ser_wr_en      (ser_wr_en),
    .ser_rd_en      (ser_rd_en),
    .ser_nack       (ser_nack)
);

// File: tb/cfg_boot_seq_bench.sv
module cfg_boot_seq_bench;
    localparam int POR = 12;
    localparam int NI  = 4;
    localparam int NW  = 8;
    localparam int DW  = 8;
    localparam int IMW = 2;
    localparam int IXW = 3;
    localparam int AW  = IMW + IXW;

    logic          clk = 1'b0;
    logic          pwr_good = 1'b0;
    logic [IMW-1:0] img_sel = '0;
    logic          store_rd_en;
    logic [AW-1:0] store_addr;
    logic [DW-1:0] store_rdata = '0;
    logic          ser_wr_en = 1'b0;
    logic          ser_rd_en = 1'b0;
    logic [IXW-1:0] ser_addr = '0;
    logic [DW-1:0] ser_wdata = '0;
    logic [DW-1:0] ser_rdata;
    logic          ser_nack;
    logic          busy;
    logic          ready;
    logic          pll_lock_start;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfg_boot_seq #(.POR_CYCLES(POR), .NUM_IMAGES(NI), .N_WORDS(NW), .DATA_W(DW)) u_cfg_boot_seq (
        .clk(clk), .pwr_good(pwr_good), .img_sel(img_sel),
        .store_rd_en(store_rd_en), .store_addr(store_addr), .store_rdata(store_rdata),
        .ser_wr_en(ser_wr_en), .ser_rd_en(ser_rd_en), .ser_addr(ser_addr),
        .ser_wdata(ser_wdata), .ser_rdata(ser_rdata), .ser_nack(ser_nack),
        .busy(busy), .ready(ready), .pll_lock_start(pll_lock_start)
    );

    function automatic int img_word(int img, int idx);
        return (img * 67 + idx * 13 + 9) & 8'hFF;
    endfunction

    // store model: one-cycle read latency
    always @(posedge clk) begin
        if (store_rd_en) begin
            store_rdata <= DW'(img_word(int'(store_addr) / NW, int'(store_addr) % NW));
        end
    end

    task automatic check_eq(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state(string req);
        check_eq(req, "busy", int'(busy), 1);
        check_eq(req, "ready", int'(ready), 0);
        check_eq(req, "pll_lock_start", int'(pll_lock_start), 0);
        check_eq(req, "store_rd_en", int'(store_rd_en), 0);
        check_eq(req, "ser_nack", int'(ser_nack), 0);
        check_eq(req, "ser_rdata", int'(ser_rdata), 0);
    endtask

    task automatic boot(int img, int abort_at);
        pwr_good = 1'b0;
        img_sel  = IMW'(img);
        repeat (2) @(negedge clk);
        check_reset_state("R8");
        pwr_good = 1'b1;
        for (int c = 1; c < POR; c++) begin
            @(negedge clk);
            check_eq("R1", "store_rd_en in timer", int'(store_rd_en), 0);
            check_eq("R1", "busy in timer", int'(busy), 1);
            if (c == 4) begin
                check_eq("R6", "nack after write in timer", int'(ser_nack), 1);
                ser_wr_en = 1'b0;
            end
            if (c == 3) begin
                ser_wr_en = 1'b1; ser_addr = 3'd1; ser_wdata = 8'hAA;
            end
        end
        for (int k = 0; k < NW; k++) begin
            @(negedge clk);
            if (k == abort_at) begin
                pwr_good = 1'b0;
                #1;
                check_reset_state("R8");
                return;
            end
            check_eq((k > 2) ? "R9" : "R2", "store_rd_en", int'(store_rd_en), 1);
            check_eq((k > 2) ? "R9" : "R2", "store_addr", int'(store_addr), img * NW + k);
            if (k == 0) check_eq("R1", "first read after timer", int'(store_rd_en), 1);
            if (k == 2) img_sel = IMW'(img ^ 1);
            if (k == 5) begin
                check_eq("R6", "nack after read in load", int'(ser_nack), 1);
                check_eq("R6", "rdata held in load", int'(ser_rdata), 0);
                ser_rd_en = 1'b0;
            end
            if (k == 4) begin
                ser_rd_en = 1'b1; ser_addr = 3'd0;
            end
        end
        @(negedge clk);
        check_eq("R4", "read strobe after image", int'(store_rd_en), 0);
        check_eq("R4", "no lock yet", int'(pll_lock_start), 0);
        check_eq("R4", "busy last write", int'(busy), 1);
        @(negedge clk);
        check_eq("R4", "lock pulse", int'(pll_lock_start), 1);
        check_eq("R4", "busy during lock", int'(busy), 1);
        ser_wr_en = 1'b1; ser_addr = 3'd3; ser_wdata = DW'(~img_word(img, 3));
        @(negedge clk);
        ser_wr_en = 1'b0;
        check_eq("R4", "lock pulse ends", int'(pll_lock_start), 0);
        check_eq("R5", "ready after lock", int'(ready), 1);
        check_eq("R5", "busy after lock", int'(busy), 0);
        check_eq("R6", "nack for lock-cycle write", int'(ser_nack), 1);
        img_sel = IMW'(img);
        for (int i = 0; i < NW; i++) begin
            ser_rd_en = 1'b1; ser_addr = IXW'(i);
            @(negedge clk);
            check_eq((img == 0) ? "R3" : "R8", "loaded word", int'(ser_rdata), img_word(img, i));
            check_eq("R7", "nack in ready", int'(ser_nack), 0);
        end
        ser_rd_en = 1'b0;
        for (int i = 0; i < NW; i++) begin
            ser_wr_en = 1'b1; ser_addr = IXW'(i); ser_wdata = DW'(255 - img_word(img, i));
            @(negedge clk);
        end
        ser_wr_en = 1'b0;
        for (int i = 0; i < NW; i++) begin
            ser_rd_en = 1'b1; ser_addr = IXW'(i);
            @(negedge clk);
            check_eq("R7", "serial written word", int'(ser_rdata), 255 - img_word(img, i));
        end
        ser_rd_en = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R5", "ready holds", int'(ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R8");
        for (int img = 0; img < NI; img++) begin
            boot(img, -1);
        end
        boot(2, 3);
        boot(1, -1);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule